// File: doc/BRIEF.md
# Peripheral Bus Clock Divider with Reload Ready Flag

This block derives a peripheral bus clock from the system clock it runs on. A programmable integer ratio between 1 and 128 sets the output period. An enable bit gates the output. Software reaches both through one 16-bit control word. The word has three write addresses: a plain write, an OR-in alias and an AND-out alias. With the two aliases, a single bit can be changed without a read-modify-write.

A new ratio never cuts a period short. The value goes into a holding register, and the counter picks it up only when it wraps. While the value waits, the ready flag in the control word reads low. The enable bit is handled the same way: the gate opens and closes only at the wrap point, which falls in the low phase of the output. The divide field is protected by a two-word key sequence. The enable bit needs no key.

There are three state machines. The key machine has the states LK_LOCKED, LK_HALF and LK_OPEN. LK_LOCKED moves to LK_HALF on the first key. LK_HALF moves to LK_OPEN on the second key. A wrong key in LK_HALF returns to LK_LOCKED. Any control write in LK_HALF or LK_OPEN also returns to LK_LOCKED, so one unlock allows exactly one ratio write. The reload machine has the states RL_READY and RL_PENDING. A ratio write moves it to RL_PENDING. A counter wrap with no new write in the same cycle returns it to RL_READY. The gate machine has the states GT_OFF and GT_ON. It moves from GT_OFF to GT_ON on a wrap while enable is set, and back on a wrap while enable is clear.

Top module: `pbus_clkdiv`

## Requirements
- R1: After reset the control word reads 0x0800 and `pclk_out` is low. That value means: ratio field (bits 6:0) is 0, ready (bit 11) is 1, enable (bit 15) is 0.
- R2: With ratio field value D, `pclk_out` repeats every D+1 system clock cycles. This holds over the whole range, D = 0 to 127.
- R3: For a ratio of N = D+1, the high phase lasts ceil(N/2) cycles and the low phase floor(N/2) cycles. With N = 1 and enable set, the output stays high.
- R4: Bit 11 reads 0 from the cycle after an accepted ratio write until the new ratio takes effect, and then reads 1.
- R5: A new ratio takes effect only when the counter wraps. Every complete high or low run of the output has the length of either the old ratio or the new one.
- R6: A ratio write is accepted only when two writes to address 3 come just before it: first 0x5A3C, then 0xC3A5. A wrong second key cancels the sequence. Each unlock allows one control write. If the write is not accepted, its ratio part leaves the readback, the ready flag and the output unchanged.
- R7: When bit 15 is clear, the output goes low at a period boundary and stays low. Enabling and disabling never shorten a high pulse.
- R8: Address 0 writes the whole word. Address 1 sets only the bits written as 1. Address 2 clears only the bits written as 1. Bit 11 cannot be written.
- R9: The enable bit can be changed through any of the three control addresses without the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the divider source |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | 0 plain write, 1 set alias, 2 clear alias, 3 key |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Control word readback: enable, ready, ratio |
| pclk_out | output | 1 | Divided, gated peripheral clock |

## Verification
The ratio is tried at 1, 2, 5, 7, 8 and 128. Comparing the measured high and low run lengths separates even ratios from odd ones and catches off-by-one errors at both ends of the range. Ratio changes are written at several offsets inside a period, and every run is checked against the old or the new length. A reload that does not wait for the wrap shows up as a short run. The enable bit is toggled at varying offsets while each high pulse is checked for full length. Wrong keys, a reused unlock and alias writes with the data bits 0 or 1 each confirm that the readback changes only where the rules allow.

// File: rtl/pbus_clkdiv_pkg.sv
package pbus_clkdiv_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_SET  = 2'd1,
        ADDR_CLR  = 2'd2,
        ADDR_KEY  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef enum logic {
        RL_READY   = 1'b0,
        RL_PENDING = 1'b1
    } reload_state_e;

    typedef enum logic {
        GT_OFF = 1'b0,
        GT_ON  = 1'b1
    } gate_state_e;
endpackage

// File: rtl/pbus_clkdiv_unlock.sv
module pbus_clkdiv_unlock
    import pbus_clkdiv_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter logic [15:0] KEY_A  = 16'h5A3C,
    parameter logic [15:0] KEY_B  = 16'hC3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              lock_open
);
    lock_state_e state_q, state_d;
    logic key_wr, ctrl_wr;

    assign key_wr  = wr_en && (reg_addr_e'(wr_addr) == ADDR_KEY);
    assign ctrl_wr = wr_en && (reg_addr_e'(wr_addr) != ADDR_KEY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: begin
                if (key_wr && wr_data == DATA_W'(KEY_A)) state_d = LK_HALF;
            end
            LK_HALF: begin
                if (key_wr)       state_d = (wr_data == DATA_W'(KEY_B)) ? LK_OPEN : LK_LOCKED;
                else if (ctrl_wr) state_d = LK_LOCKED;
            end
            LK_OPEN: begin
                if (key_wr)       state_d = (wr_data == DATA_W'(KEY_A)) ? LK_HALF : LK_LOCKED;
                else if (ctrl_wr) state_d = LK_LOCKED;
            end
            default: state_d = LK_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        lock_open = (state_q == LK_OPEN);
    end
endmodule

// File: rtl/pbus_clkdiv_regs.sv
module pbus_clkdiv_regs
    import pbus_clkdiv_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 7,
    parameter int EN_BIT  = 15,
    parameter int RDY_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock_open,
    input  logic              ready,
    output logic              en_req,
    output logic              load_stb,
    output logic [DIV_W-1:0]  load_div,
    output logic [DATA_W-1:0] rd_data
);
    logic [DIV_W-1:0] prog_div_q, div_d;
    logic             en_q, en_d, div_touch, ctrl_wr;
    logic             unused_data;

    assign unused_data = ^wr_data;
    assign ctrl_wr     = wr_en && (reg_addr_e'(wr_addr) != ADDR_KEY);

    always_comb begin
        div_d     = prog_div_q;
        en_d      = en_q;
        div_touch = 1'b0;
        unique case (reg_addr_e'(wr_addr))
            ADDR_CTRL: begin
                div_d     = wr_data[DIV_W-1:0];
                en_d      = wr_data[EN_BIT];
                div_touch = 1'b1;
            end
            ADDR_SET: begin
                div_d     = prog_div_q | wr_data[DIV_W-1:0];
                en_d      = en_q | wr_data[EN_BIT];
                div_touch = (wr_data[DIV_W-1:0] != '0);
            end
            ADDR_CLR: begin
                div_d     = prog_div_q & ~wr_data[DIV_W-1:0];
                en_d      = en_q & ~wr_data[EN_BIT];
                div_touch = (wr_data[DIV_W-1:0] != '0);
            end
            ADDR_KEY: begin
                div_touch = 1'b0;
            end
        endcase
    end

    assign load_stb = ctrl_wr && lock_open && div_touch;
    assign load_div = div_d;
    assign en_req   = en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_div_q <= '0;
            en_q       <= 1'b0;
        end else begin
            if (ctrl_wr)  en_q       <= en_d;
            if (load_stb) prog_div_q <= div_d;
        end
    end

    always_comb begin
        rd_data                = '0;
        rd_data[DIV_W-1:0]     = prog_div_q;
        rd_data[RDY_BIT]       = ready;
        rd_data[EN_BIT]        = en_q;
    end
endmodule

// File: rtl/pbus_clkdiv_core.sv
module pbus_clkdiv_core
    import pbus_clkdiv_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [DIV_W-1:0] load_div,
    input  logic             en_req,
    output logic             ready,
    output logic             gate_on,
    output logic             wrap,
    output logic [DIV_W-1:0] active_div,
    output logic [DIV_W-1:0] div_cnt,
    output logic             pclk_out
);
    reload_state_e    rl_q, rl_d;
    gate_state_e      gt_q, gt_d;
    logic [DIV_W-1:0] cnt_q, act_q, pend_q;
    logic             pclk_q, take_new;

    assign wrap     = (cnt_q == act_q);
    assign take_new = (rl_q == RL_PENDING) && wrap && !load_stb;

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rl_q <= RL_READY;
            gt_q <= GT_OFF;
        end else begin
            rl_q <= rl_d;
            gt_q <= gt_d;
        end
    end

    // reload transitions
    always_comb begin
        rl_d = rl_q;
        unique case (rl_q)
            RL_READY:   if (load_stb) rl_d = RL_PENDING;
            RL_PENDING: if (load_stb) rl_d = RL_PENDING;
                        else if (wrap) rl_d = RL_READY;
        endcase
    end

    // gate transitions: only at the wrap, which lies in the low phase
    always_comb begin
        gt_d = gt_q;
        unique case (gt_q)
            GT_OFF: if (en_req && wrap)  gt_d = GT_ON;
            GT_ON:  if (!en_req && wrap) gt_d = GT_OFF;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= '0;
            pend_q <= '0;
            pclk_q <= 1'b0;
        end else begin
            cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
            if (load_stb) pend_q <= load_div;
            if (take_new) act_q  <= pend_q;
            pclk_q <= (gt_q == GT_ON) && (cnt_q <= (act_q >> 1));
        end
    end

    // outputs
    always_comb begin
        ready      = (rl_q == RL_READY);
        gate_on    = (gt_q == GT_ON);
        active_div = act_q;
        div_cnt    = cnt_q;
        pclk_out   = pclk_q;
    end
endmodule

// File: rtl/pbus_clkdiv.sv
module pbus_clkdiv #(
    parameter int          DIV_W   = 7,
    parameter int          DATA_W  = 16,
    parameter int          EN_BIT  = 15,
    parameter int          RDY_BIT = 11,
    parameter logic [15:0] KEY_A   = 16'h5A3C,
    parameter logic [15:0] KEY_B   = 16'hC3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              pclk_out
);
    logic             lock_open, en_req, load_stb, ready, gate_on, wrap;
    logic [DIV_W-1:0] load_div, active_div, div_cnt;

    pbus_clkdiv_unlock #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .lock_open (lock_open)
    );

    pbus_clkdiv_regs #(
        .DATA_W  (DATA_W),
        .DIV_W   (DIV_W),
        .EN_BIT  (EN_BIT),
        .RDY_BIT (RDY_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .lock_open (lock_open),
        .ready     (ready),
        .en_req    (en_req),
        .load_stb  (load_stb),
        .load_div  (load_div),
        .rd_data   (rd_data)
    );

    pbus_clkdiv_core #(
        .DIV_W (DIV_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_stb   (load_stb),
        .load_div   (load_div),
        .en_req     (en_req),
        .ready      (ready),
        .gate_on    (gate_on),
        .wrap       (wrap),
        .active_div (active_div),
        .div_cnt    (div_cnt),
        .pclk_out   (pclk_out)
    );
endmodule

// File: rtl/pbus_clkdiv_chk.sv
module pbus_clkdiv_chk
    import pbus_clkdiv_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int DATA_W  = 16,
    parameter int RDY_BIT = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              pclk_out,
    input logic              load_stb,
    input logic              lock_open,
    input logic              gate_on,
    input logic              wrap,
    input logic [DIV_W-1:0]  active_div,
    input logic [DIV_W-1:0]  div_cnt
);
    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= active_div);

    assert_ready_drops_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !rd_data[RDY_BIT]);

    assert_reload_only_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_div != $past(active_div)) |-> $past(wrap));

    assert_locked_ratio_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_KEY && !lock_open) |=> $stable(rd_data[DIV_W-1:0]));

    assert_gate_moves_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on != $past(gate_on)) |-> $past(wrap));

    assert_gated_output_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_on && $past(!gate_on)) |-> !pclk_out);
endmodule

bind pbus_clkdiv pbus_clkdiv_chk #(
    .DIV_W   (DIV_W),
    .DATA_W  (DATA_W),
    .RDY_BIT (RDY_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_data    (rd_data),
    .pclk_out   (pclk_out),
    .load_stb   (load_stb),
    .lock_open  (lock_open),
    .gate_on    (gate_on),
    .wrap       (wrap),
    .active_div (active_div),
    .div_cnt    (div_cnt)
);

// File: tb/pbus_clkdiv_bench.sv
module pbus_clkdiv_bench;
    localparam logic [15:0] KA = 16'h5A3C;
    localparam logic [15:0] KB = 16'hC3A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        pclk_out;

    always #2 clk = ~clk;

    pbus_clkdiv u_pbus_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .pclk_out (pclk_out)
    );

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } period_t;

    period_t exp_q[$];
    int    n_cmp = 0, n_bad = 0;
    int    mon_epoch = 0;
    bit    armed = 1'b0, strict = 1'b0, done = 1'b0;
    int    s_hi_a, s_hi_b, s_lo_a, s_lo_b;
    string s_tag = "";

    task automatic check_eq(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_any(string tag, string what, int act, int a, int b);
        n_cmp++;
        if (act != a && act != b) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d or %0d", tag, what, act, a, b);
        end
    endtask

    // monitor: measures run lengths of pclk_out and compares against the queue
    initial begin
        int run = 0, last_hi = 0, seen_epoch = 0;
        bit prev = 1'b0, cur, rise_seen = 1'b0, hi_ok = 1'b0;
        forever begin
            @(negedge clk);
            if (seen_epoch != mon_epoch) begin
                seen_epoch = mon_epoch;
                rise_seen  = 1'b0;
                hi_ok      = 1'b0;
            end
            cur = pclk_out;
            if (cur == prev) begin
                run++;
            end else begin
                if (prev) begin
                    if (rise_seen) begin
                        last_hi = run;
                        hi_ok   = 1'b1;
                        if (strict) check_any(s_tag, "high run", run, s_hi_a, s_hi_b);
                    end
                end else begin
                    if (hi_ok) begin
                        if (strict && s_lo_a > 0) check_any(s_tag, "low run", run, s_lo_a, s_lo_b);
                        if (armed && exp_q.size() > 0) begin
                            period_t e;
                            e = exp_q.pop_front();
                            check_eq(e.tag, "high cycles", last_hi, e.hi);
                            check_eq(e.tag, "low cycles", run, e.lo);
                        end
                    end
                    rise_seen = 1'b1;
                    hi_ok     = 1'b0;
                end
                run = 1;
            end
            prev = cur;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'd0;
    endtask

    task automatic unlock();
        wr(2'd3, KA);
        wr(2'd3, KB);
    endtask

    task automatic wait_ready(string tag);
        for (int i = 0; i < 400; i++) begin
            if (rd_data[11]) break;
            @(negedge clk);
        end
        check_eq(tag, "ready after reload", int'(rd_data[11]), 1);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_periods(int hi, int lo, int k, string tag);
        period_t e;
        mon_epoch++;
        cycles(2);
        for (int i = 0; i < k; i++) begin
            e.hi = hi; e.lo = lo; e.tag = tag;
            exp_q.push_back(e);
        end
        armed = 1'b1;
        for (int i = 0; i < (hi + lo) * (k + 3) + 20; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        check_eq(tag, "periods left unobserved", exp_q.size(), 0);
        exp_q.delete();
        armed = 1'b0;
    endtask

    initial begin
        cycles(5);
        // R1: reset state
        check_eq("R1", "rd_data in reset", int'(rd_data), 'h0800);
        check_eq("R1", "pclk_out in reset", int'(pclk_out), 0);
        rst_n = 1'b1;
        cycles(10);
        check_eq("R7", "output while disabled", int'(pclk_out), 0);

        // R9 enable without key, R6 ratio ignored while locked
        wr(2'd0, 16'h8005);
        check_eq("R6", "locked write readback", int'(rd_data), 'h8800);
        cycles(5);
        check_eq("R3", "ratio 1 held high", int'(pclk_out), 1);

        // R4 ready flag around an accepted write, ratio 5
        unlock();
        wr(2'd0, 16'h8004);
        check_eq("R4", "ready low while pending", int'(rd_data[11]), 0);
        wait_ready("R4");
        check_eq("R4", "readback after reload", int'(rd_data), 'h8804);
        expect_periods(3, 2, 3, "R2 ratio5");

        // R6 unlock is consumed by one write
        wr(2'd0, 16'h8010);
        check_eq("R6", "second write without key", int'(rd_data), 'h8804);
        expect_periods(3, 2, 2, "R6 ratio kept");

        // R6 wrong second key
        wr(2'd3, KA);
        wr(2'd3, 16'h1234);
        wr(2'd0, 16'h8010);
        check_eq("R6", "wrong key readback", int'(rd_data), 'h8804);
        check_eq("R6", "wrong key ready", int'(rd_data[11]), 1);

        // R8 set alias: 4 | 3 = 7 -> ratio 8
        unlock();
        wr(2'd1, 16'h0003);
        wait_ready("R8");
        check_eq("R8", "set alias readback", int'(rd_data), 'h8807);
        expect_periods(4, 4, 2, "R3 even ratio8");

        // R8 clear alias: 7 & ~1 = 6 -> ratio 7
        unlock();
        wr(2'd2, 16'h0001);
        wait_ready("R8");
        check_eq("R8", "clear alias readback", int'(rd_data), 'h8806);
        expect_periods(4, 3, 2, "R3 odd ratio7");

        // R9 / R7 gate off and on through the aliases, no key
        wr(2'd2, 16'h8000);
        check_eq("R9", "clear enable readback", int'(rd_data), 'h0806);
        cycles(20);
        check_eq("R7", "gated output low", int'(pclk_out), 0);
        wr(2'd1, 16'h8000);
        check_eq("R9", "set enable readback", int'(rd_data), 'h8806);
        expect_periods(4, 3, 2, "R7 re-enabled");

        // R8 bit 11 not writable; ratio 2
        unlock();
        wr(2'd0, 16'h8801);
        check_eq("R8", "bit11 write, pending", int'(rd_data), 'h8001);
        wait_ready("R8");
        check_eq("R8", "readback ratio2", int'(rd_data), 'h8801);
        expect_periods(1, 1, 3, "R2 ratio2");

        // R2 largest ratio
        unlock();
        wr(2'd0, 16'h807F);
        wait_ready("R2");
        expect_periods(64, 64, 1, "R2 ratio128");

        // R5 reload at various offsets, ratio 8 -> 3
        for (int off = 0; off < 5; off++) begin
            unlock();
            wr(2'd0, 16'h8807);
            wait_ready("R5");
            cycles(20);
            s_hi_a = 4; s_hi_b = 2; s_lo_a = 4; s_lo_b = 1; s_tag = "R5";
            mon_epoch++;
            strict = 1'b1;
            cycles(off * 3 + 1);
            unlock();
            wr(2'd0, 16'h8802);
            wait_ready("R5");
            cycles(20);
            strict = 1'b0;
            expect_periods(2, 1, 1, "R5 new ratio");
        end

        // R7 gating at various offsets, ratio 6
        unlock();
        wr(2'd0, 16'h8805);
        wait_ready("R7");
        cycles(20);
        s_hi_a = 3; s_hi_b = 3; s_lo_a = 0; s_lo_b = 0; s_tag = "R7";
        mon_epoch++;
        strict = 1'b1;
        for (int off = 0; off < 6; off++) begin
            cycles(off + 1);
            wr(2'd2, 16'h8000);
            cycles(off + 7);
            wr(2'd1, 16'h8000);
        end
        cycles(20);
        strict = 1'b0;
        expect_periods(3, 3, 2, "R7 after toggling");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule